// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transceiver

This block sends and receives start/stop framed characters on a single serial line in each direction. A small mode register, written through a plain write port, sets the frame shape: seven or eight data bits, an optional parity bit of either sense, one or two transmit stop bits, and a multiprocessor framing option. In multiprocessor framing, one extra bit follows the data and carries an address/data marker in place of parity. All timing is driven by an external oversampling tick that pulses once per sixteenth of a bit time, so one bit lasts `OSR` ticks.

The transmitter accepts a byte when `tx_ready` is high and `tx_load` is pulsed. It drives a low start bit, the data least significant bit first, the optional extra bit and the stop bits, then returns the line to the idle high level. The receiver synchronises its input, qualifies a start bit at its half-bit point, samples every later bit in its middle and presents the character with a one-cycle `rx_valid` strobe together with the parity error flag, the framing error flag and the received marker bit. Each direction takes a snapshot of the mode at the start of its frame, so a register write during a frame affects only the next one.

Top module: `async_serial_xcvr`

## Requirements
- R1: The mode register resets to all zeros, which gives eight data bits, no parity and one stop bit. A write of `mode_wdata` with `mode_we` high is in force from the next cycle. The field positions are: bit 6 length, bit 5 parity on, bit 4 parity sense, bit 3 stop count, bit 2 multiprocessor framing. Bits 7, 1 and 0 have no effect.
- R2: The line idles high. A transmitted frame is a low start bit, the data bits least significant first, the optional extra bit, then the stop bits, each of `OSR` ticks. `tx_ready` is high only while the transmitter is idle, and a load is accepted only then.
- R3: With bit 6 at 1, frames carry 7 data bits; bit 7 of `tx_data` is not sent and bit 7 of `rx_data` reads 0. With bit 6 at 0, frames carry 8 data bits.
- R4: With bit 5 at 1 (and bit 2 at 0), a parity bit follows the data on transmit, and on receive a mismatch sets `rx_perr`. With bit 5 at 0, no parity bit is sent and `rx_perr` stays 0.
- R5: Bit 4 at 0 selects even parity (the data bits plus parity bit hold an even count of ones); bit 4 at 1 selects odd parity. Only the transmitted data bits count.
- R6: Bit 3 at 0 sends one stop bit and bit 3 at 1 sends two; `tx_ready` stays low until the last stop bit has lasted `OSR` ticks.
- R7: The receiver checks only the first stop bit whatever bit 3 holds; a low level right after it is taken as the start of the next character, so back-to-back single-stop frames are all received with bit 3 at 1.
- R8: With bit 2 at 1, bits 5 and 4 are ignored: the extra bit after the data is `tx_mpb` on transmit, is reported on `rx_mpb` on receive, and `rx_perr` stays 0. With bit 2 at 0, `rx_mpb` reads 0.
- R9: A first stop bit sampled low sets `rx_ferr` with the strobe; the receiver then waits for the line to go high before looking for a new start bit.
- R10: A low level on the receive line that has gone high again by the half-bit point of a start bit is rejected and produces no character.
- R11: A mode write during a frame does not change that frame in either direction; it applies from the next frame.
- R12: `rx_valid` is a single-cycle pulse, and `rx_data`, `rx_mpb`, `rx_perr` and `rx_ferr` are valid in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Oversampling enable, `OSR` pulses per bit time |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 8 | Mode register write value |
| tx_load | input | 1 | Load a character into the transmitter |
| tx_data | input | 8 | Character to send |
| tx_mpb | input | 1 | Marker bit sent in multiprocessor framing |
| tx_ready | output | 1 | Transmitter idle and able to take a load |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| rx_valid | output | 1 | One-cycle strobe: a character has been received |
| rx_data | output | 8 | Received character |
| rx_mpb | output | 1 | Received marker bit in multiprocessor framing |
| rx_perr | output | 1 | Parity error on the received character |
| rx_ferr | output | 1 | Framing error on the received character |

## Verification
On every cycle the assertions hold the transmit line high while idle, tie a frame start to an accepted load, forbid the line from moving between ticks, and bind each received strobe to one cycle with a clear top bit in 7-bit frames and no parity error when parity is off or marker framing is on. Bit ordering, parity values, stop bit counts, the deferred effect of a mode write, false start rejection, framing error recovery and back-to-back reception across a low second stop position depend on whole frame sequences, so only the bench scenarios show them: the bench decodes the transmit line at every bit middle and drives the receive line bit by bit with deliberately broken frames.

// File: rtl/aser_pkg.sv
package aser_pkg;

    localparam int MODE_W = 8;
    localparam int CHAR_W = 8;

    // Frame shape snapshot, one flop per mode field in use
    typedef struct packed {
        logic char7;
        logic par_en;
        logic par_odd;
        logic stop2;
        logic mp;
    } frame_cfg_t;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_EXTRA,
        TX_STOP1,
        TX_STOP2
    } tx_st_t;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_EXTRA,
        RX_STOP,
        RX_HOLD
    } rx_st_t;

    function automatic frame_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        frame_cfg_t c;
        c.char7   = m[6];
        c.par_en  = m[5];
        c.par_odd = m[4];
        c.stop2   = m[3];
        c.mp      = m[2];
        return c;
    endfunction

    // Parity bit for the bits actually carried by the frame
    function automatic logic par_of(input logic [CHAR_W-1:0] d, input logic char7,
                                    input logic odd);
        logic [CHAR_W-1:0] m;
        m = char7 ? {1'b0, d[CHAR_W-2:0]} : d;
        return (^m) ^ odd;
    endfunction

endpackage

// File: rtl/aser_mode_reg.sv
module aser_mode_reg
    import aser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output frame_cfg_t        cfg
);

    typedef struct packed {
        frame_cfg_t cfg;
    } mode_regs_t;

    mode_regs_t q, d;

    // Bits outside the five fields carry no function
    logic unused_mode_bits;
    assign unused_mode_bits = ^{wdata[7], wdata[1:0]};

    always_comb begin
        d = q;
        if (we) begin
            d.cfg = decode_mode(wdata);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cfg = q.cfg;

endmodule

// File: rtl/aser_tx.sv
module aser_tx
    import aser_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg_in,
    input  logic              load,
    input  logic [CHAR_W-1:0] data,
    input  logic              mpb_in,
    output logic              ready,
    output logic              txd
);

    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);

    typedef struct packed {
        tx_st_t            st;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        bitn;
        logic [CHAR_W-1:0] shreg;
        logic              extra;
        frame_cfg_t        cfg;
    } tx_regs_t;

    tx_regs_t q, d;
    logic [2:0] last_bit;

    assign last_bit = q.cfg.char7 ? 3'd6 : 3'd7;

    always_comb begin
        d = q;
        if (q.st == TX_IDLE) begin
            if (load) begin
                d.st    = TX_START;
                d.cnt   = '0;
                d.bitn  = '0;
                d.shreg = data;
                d.cfg   = cfg_in;
                d.extra = cfg_in.mp ? mpb_in : par_of(data, cfg_in.char7, cfg_in.par_odd);
            end
        end else if (tick) begin
            if (q.cnt != LAST_TICK) begin
                d.cnt = q.cnt + 1'b1;
            end else begin
                d.cnt = '0;
                unique case (q.st)
                    TX_START: d.st = TX_DATA;
                    TX_DATA: begin
                        d.shreg = q.shreg >> 1;
                        if (q.bitn == last_bit) begin
                            d.st = (q.cfg.mp || q.cfg.par_en) ? TX_EXTRA : TX_STOP1;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end
                    TX_EXTRA: d.st = TX_STOP1;
                    TX_STOP1: d.st = q.cfg.stop2 ? TX_STOP2 : TX_IDLE;
                    TX_STOP2: d.st = TX_IDLE;
                    default:  d.st = TX_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: TX_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    always_comb begin
        unique case (q.st)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = q.shreg[0];
            TX_EXTRA: txd = q.extra;
            default:  txd = 1'b1;
        endcase
    end

    assign ready = (q.st == TX_IDLE);

endmodule

// File: rtl/aser_rx.sv
module aser_rx
    import aser_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg_in,
    input  logic              rxd,
    output logic              valid,
    output logic [CHAR_W-1:0] data,
    output logic              mpb,
    output logic              perr,
    output logic              ferr,
    output frame_cfg_t        cfg_out
);

    localparam int CNT_W = $clog2(OSR);
    localparam logic [CNT_W-1:0] LAST_TICK = CNT_W'(OSR - 1);
    localparam logic [CNT_W-1:0] MID_TICK  = CNT_W'(OSR / 2 - 1);

    // Input synchroniser, reset to the idle level
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rx_s;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= rxd;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '1;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], rxd};
            end
        end
    endgenerate

    assign rx_s = sync_q[SYNC_STAGES-1];

    typedef struct packed {
        rx_st_t            st;
        logic [CNT_W-1:0]  cnt;
        logic [2:0]        bitn;
        logic [CHAR_W-1:0] shreg;
        logic              extra;
        frame_cfg_t        cfg;
        logic              valid;
        logic [CHAR_W-1:0] data;
        logic              mpb;
        logic              perr;
        logic              ferr;
    } rx_regs_t;

    rx_regs_t q, d;
    logic [2:0]        last_bit;
    logic [CHAR_W-1:0] word;

    assign last_bit = q.cfg.char7 ? 3'd6 : 3'd7;
    assign word     = q.cfg.char7 ? {1'b0, q.shreg[CHAR_W-1:1]} : q.shreg;

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        unique case (q.st)
            RX_IDLE: begin
                if (tick && !rx_s) begin
                    d.st   = RX_START;
                    d.cnt  = '0;
                    d.bitn = '0;
                    d.cfg  = cfg_in;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (q.cnt != MID_TICK) begin
                        d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.cnt = '0;
                        d.st  = rx_s ? RX_IDLE : RX_DATA;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (q.cnt != LAST_TICK) begin
                        d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.cnt   = '0;
                        d.shreg = {rx_s, q.shreg[CHAR_W-1:1]};
                        if (q.bitn == last_bit) begin
                            d.st = (q.cfg.mp || q.cfg.par_en) ? RX_EXTRA : RX_STOP;
                        end else begin
                            d.bitn = q.bitn + 1'b1;
                        end
                    end
                end
            end
            RX_EXTRA: begin
                if (tick) begin
                    if (q.cnt != LAST_TICK) begin
                        d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.cnt   = '0;
                        d.extra = rx_s;
                        d.st    = RX_STOP;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (q.cnt != LAST_TICK) begin
                        d.cnt = q.cnt + 1'b1;
                    end else begin
                        d.cnt   = '0;
                        d.valid = 1'b1;
                        d.data  = word;
                        d.mpb   = q.cfg.mp & q.extra;
                        d.perr  = q.cfg.par_en && !q.cfg.mp &&
                                  (par_of(word, q.cfg.char7, q.cfg.par_odd) != q.extra);
                        d.ferr  = !rx_s;
                        d.st    = rx_s ? RX_IDLE : RX_HOLD;
                    end
                end
            end
            RX_HOLD: begin
                if (rx_s) d.st = RX_IDLE;
            end
            default: d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign valid   = q.valid;
    assign data    = q.data;
    assign mpb     = q.mpb;
    assign perr    = q.perr;
    assign ferr    = q.ferr;
    assign cfg_out = q.cfg;

endmodule

// File: rtl/async_serial_xcvr.sv
module async_serial_xcvr
    import aser_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       mode_we,
    input  logic [7:0] mode_wdata,
    input  logic       tx_load,
    input  logic [7:0] tx_data,
    input  logic       tx_mpb,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    output logic       rx_valid,
    output logic [7:0] rx_data,
    output logic       rx_mpb,
    output logic       rx_perr,
    output logic       rx_ferr
);

    frame_cfg_t mode_cfg;
    frame_cfg_t rx_cfg;

    aser_mode_reg u_mode (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mode_we),
        .wdata (mode_wdata),
        .cfg   (mode_cfg)
    );

    aser_tx #(.OSR(OSR)) u_tx (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cfg_in (mode_cfg),
        .load   (tx_load),
        .data   (tx_data),
        .mpb_in (tx_mpb),
        .ready  (tx_ready),
        .txd    (txd)
    );

    aser_rx #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cfg_in  (mode_cfg),
        .rxd     (rxd),
        .valid   (rx_valid),
        .data    (rx_data),
        .mpb     (rx_mpb),
        .perr    (rx_perr),
        .ferr    (rx_ferr),
        .cfg_out (rx_cfg)
    );

endmodule

// File: rtl/aser_xcvr_chk.sv
module aser_xcvr_chk
    import aser_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tick,
    input logic       mode_we,
    input logic [7:0] mode_wdata,
    input frame_cfg_t mode_cfg,
    input logic       tx_load,
    input logic       tx_ready,
    input logic       txd,
    input logic       rx_valid,
    input logic [7:0] rx_data,
    input logic       rx_perr,
    input frame_cfg_t rx_cfg
);

    assert_mode_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (mode_cfg == decode_mode($past(mode_wdata))));

    assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ready |-> txd);

    assert_load_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_load && tx_ready) |=> (!txd && !tx_ready));

    assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(tx_load && tx_ready)) |=> $stable(txd));

    assert_short_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_cfg.char7) |-> !rx_data[7]);

    assert_no_parity_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_cfg.par_en) |-> !rx_perr);

    assert_marker_no_perr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_cfg.mp) |-> !rx_perr);

    assert_valid_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

endmodule

bind async_serial_xcvr aser_xcvr_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .mode_we    (mode_we),
    .mode_wdata (mode_wdata),
    .mode_cfg   (mode_cfg),
    .tx_load    (tx_load),
    .tx_ready   (tx_ready),
    .txd        (txd),
    .rx_valid   (rx_valid),
    .rx_data    (rx_data),
    .rx_perr    (rx_perr),
    .rx_cfg     (rx_cfg)
);

// File: tb/async_serial_xcvr_bench.sv
`timescale 1ns/1ps
module async_serial_xcvr_bench;

    localparam int OSR      = 16;
    localparam int TICK_DIV = 4;
    localparam int MAX_CYC  = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       mode_we = 1'b0;
    logic [7:0] mode_wdata = '0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_data = '0;
    logic       tx_mpb = 1'b0;
    logic       loop = 1'b1;
    logic       line_drv = 1'b1;
    logic       rxd;
    logic       tx_ready, txd, rx_valid, rx_mpb, rx_perr, rx_ferr;
    logic [7:0] rx_data;

    int   total = 0;
    int   bad = 0;
    int   cyc = 0;
    logic tx_busy = 1'b0;
    logic [7:0] cur_mode = '0;

    // Scoreboard queues
    logic [10:0] rx_exp_q[$];
    string       rx_tag_q[$];
    int          tx_n_q[$];
    logic [11:0] tx_b_q[$];
    string       tx_tag_q[$];

    assign rxd = loop ? txd : line_drv;

    async_serial_xcvr u_async_serial_xcvr (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .tx_load(tx_load), .tx_data(tx_data), .tx_mpb(tx_mpb),
        .tx_ready(tx_ready), .txd(txd), .rxd(rxd),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_mpb(rx_mpb),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            tick = (cyc % TICK_DIV == 0);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (tick) c++;
        end
    endtask

    // Expected line bits, index 0 is the start bit
    function automatic void build(input logic [7:0] m, input logic [7:0] d, input logic mpb,
                                  output int n, output logic [11:0] b);
        int nd;
        b = '1;
        n = 0;
        b[n] = 1'b0; n++;
        nd = m[6] ? 7 : 8;
        for (int i = 0; i < nd; i++) begin
            b[n] = d[i]; n++;
        end
        if (m[2]) begin
            b[n] = mpb; n++;
        end else if (m[5]) begin
            b[n] = (^(d & (m[6] ? 8'h7F : 8'hFF))) ^ m[4]; n++;
        end
        b[n] = 1'b1; n++;
        if (m[3]) begin
            b[n] = 1'b1; n++;
        end
    endfunction

    function automatic logic [10:0] rx_item(input logic [7:0] m, input logic [7:0] d,
                                            input logic mpb, input logic pe, input logic fe);
        return {d & (m[6] ? 8'h7F : 8'hFF), m[2] & mpb, pe, fe};
    endfunction

    task automatic set_mode(input logic [7:0] v);
        @(negedge clk);
        mode_we = 1'b1;
        mode_wdata = v;
        cur_mode = v;
        @(negedge clk);
        mode_we = 1'b0;
    endtask

    task automatic send(input logic [7:0] d, input logic mpb, input string tag);
        int n;
        logic [11:0] b;
        @(negedge clk);
        while (!tx_ready) @(negedge clk);
        build(cur_mode, d, mpb, n, b);
        tx_n_q.push_back(n);
        tx_b_q.push_back(b);
        tx_tag_q.push_back(tag);
        rx_exp_q.push_back(rx_item(cur_mode, d, mpb, 1'b0, 1'b0));
        rx_tag_q.push_back(tag);
        tx_data = d;
        tx_mpb = mpb;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
    endtask

    // Drive the receive line directly with a frame built from pat_mode
    task automatic bang(input logic [7:0] pat_mode, input logic [7:0] d, input logic mpb,
                        input logic bad_par, input logic bad_stop, input string tag);
        int n;
        logic [11:0] b;
        build(pat_mode, d, mpb, n, b);
        if (bad_par) b[(pat_mode[6] ? 7 : 8) + 1] = ~b[(pat_mode[6] ? 7 : 8) + 1];
        if (bad_stop) b[n - 1] = 1'b0;
        rx_exp_q.push_back(rx_item(pat_mode, d, mpb, bad_par, bad_stop));
        rx_tag_q.push_back(tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            line_drv = b[i];
            wait_ticks(OSR);
        end
        @(negedge clk);
        line_drv = 1'b1;
    endtask

    task automatic settle();
        @(negedge clk);
        while (rx_exp_q.size() != 0 || tx_n_q.size() != 0 || tx_busy) @(negedge clk);
        wait_ticks(24);
        @(negedge clk);
    endtask

    // Transmit line monitor: decodes each bit at its middle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && txd === 1'b0) begin
                if (tx_n_q.size() == 0) begin
                    chk("R2 unexpected frame on txd", 32'd1, 32'd0);
                end else begin
                    int n;
                    logic [11:0] b;
                    string tag;
                    n = tx_n_q.pop_front();
                    b = tx_b_q.pop_front();
                    tag = tx_tag_q.pop_front();
                    tx_busy = 1'b1;
                    for (int i = 0; i < n; i++) begin
                        wait_ticks(OSR / 2);
                        @(negedge clk);
                        chk({tag, " txd bit"}, {31'd0, txd}, {31'd0, b[i]});
                        chk({tag, " R2 ready low in frame"}, {31'd0, tx_ready}, 32'd0);
                        wait_ticks(OSR / 2);
                    end
                    wait_ticks(OSR / 2);
                    @(negedge clk);
                    chk({tag, " R6 idle after stops"}, {30'd0, txd, tx_ready}, 32'd3);
                    tx_busy = 1'b0;
                end
            end
        end
    end

    // Receive monitor (R12: all fields checked in the strobe cycle)
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && rx_valid === 1'b1) begin
                if (rx_exp_q.size() == 0) begin
                    chk("R10 unexpected character", 32'd1, 32'd0);
                end else begin
                    logic [10:0] e;
                    string tag;
                    e = rx_exp_q.pop_front();
                    tag = rx_tag_q.pop_front();
                    chk({tag, " rx fields"}, {21'd0, rx_data, rx_mpb, rx_perr, rx_ferr},
                        {21'd0, e});
                end
            end
        end
    end

    initial begin
        repeat (MAX_CYC) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset txd", {31'd0, txd}, 32'd1);
        chk("R1 reset tx_ready", {31'd0, tx_ready}, 32'd1);
        chk("R12 reset rx_valid", {31'd0, rx_valid}, 32'd0);

        // R1 R2 default eight data bits, no parity, one stop
        send(8'hA5, 1'b0, "R1 default frame");
        settle();
        send(8'h3C, 1'b0, "R2 default frame");
        settle();

        // R3 seven data bits
        set_mode(8'h40);
        send(8'hFF, 1'b0, "R3 seven bit");
        settle();
        // R1 bits 7,1,0 have no effect
        set_mode(8'h83);
        send(8'h81, 1'b0, "R1 spare bits");
        settle();

        // R4 R5 even parity
        set_mode(8'h20);
        send(8'h03, 1'b0, "R4 even parity zero");
        settle();
        send(8'h07, 1'b0, "R5 even parity one");
        settle();
        // R5 odd parity, 8 and 7 bits
        set_mode(8'h30);
        send(8'h07, 1'b0, "R5 odd parity");
        settle();
        set_mode(8'h70);
        send(8'h81, 1'b0, "R5 odd parity seven bit");
        settle();

        // R6 two stop bits
        set_mode(8'h08);
        send(8'h96, 1'b0, "R6 two stops");
        settle();

        // R8 marker framing overrides parity settings
        set_mode(8'h34);
        send(8'h5A, 1'b1, "R8 marker one");
        settle();
        send(8'h5A, 1'b0, "R8 marker zero");
        settle();

        // R11 write during a frame applies to the next frame
        set_mode(8'h00);
        send(8'h55, 1'b0, "R11 old format frame");
        repeat (200) @(negedge clk);
        set_mode(8'h28);
        settle();
        send(8'h55, 1'b0, "R11 new format frame");
        settle();

        // Direct drive of the receive line
        loop = 1'b0;
        set_mode(8'h00);
        bang(8'h00, 8'h12, 1'b0, 1'b0, 1'b1, "R9 framing error");
        wait_ticks(40);
        bang(8'h00, 8'h6E, 1'b0, 1'b0, 1'b0, "R9 recovery frame");
        settle();

        set_mode(8'h20);
        bang(8'h20, 8'h03, 1'b0, 1'b1, 1'b0, "R4 parity error");
        settle();

        // R7 back-to-back single-stop frames with two stops selected
        set_mode(8'h08);
        bang(8'h00, 8'h5A, 1'b0, 1'b0, 1'b0, "R7 first frame");
        bang(8'h00, 8'hC3, 1'b0, 1'b0, 1'b0, "R7 second frame");
        settle();

        // R10 short low pulse rejected
        set_mode(8'h00);
        @(negedge clk);
        line_drv = 1'b0;
        wait_ticks(3);
        @(negedge clk);
        line_drv = 1'b1;
        wait_ticks(40);
        @(negedge clk);
        chk("R10 no character after glitch", {31'd0, rx_valid}, 32'd0);
        bang(8'h00, 8'h99, 1'b0, 1'b0, 1'b0, "R10 frame after glitch");
        settle();

        chk("R12 rx queue drained", rx_exp_q.size(), 32'd0);
        chk("R2 tx queue drained", tx_n_q.size(), 32'd0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule